// File: doc/BRIEF.md
# Mixed-Sign Saturating Lane Accumulator

This block adds a source vector into an accumulator vector lane by lane and clamps each lane to the range of its result type. The two operands never share a signedness. In the unsigned-result operation the source lane is read as signed and the accumulator lane as unsigned, and the result is unsigned. In the signed-result operation the source lane is read as unsigned and the accumulator lane as signed, and the result is signed. Lanes are 8, 16, 32 or 64 bits wide inside a 128-bit register.

Three shapes are supported. Scalar computes only the lowest lane. Half vector covers the low 64 bits. Full vector covers all 128 bits. Bits outside the processed lanes are written as zero. A sticky flag records that at least one live lane clamped since it was last cleared. Results appear on a registered output one cycle after the request strobe. The one encoding that cannot be executed, 64-bit lanes in half vector mode, is reported on its own output and has no effect on any state.

Top module: `mixsat_acc`

## Requirements
- R1: With `opSigned`=0, every live lane yields sign-extended source plus zero-extended accumulator. A sum above the lane's unsigned maximum yields all ones, a negative sum yields zero, and any other sum is passed through.
- R2: With `opSigned`=1, every live lane yields zero-extended source plus sign-extended accumulator, clamped to the signed maximum or signed minimum of the lane width.
- R3: `laneSize` encodes 0=8, 1=16, 2=32 and 3=64-bit lanes. Lane k occupies bits [k*W +: W] of every vector. Each lane is summed and clamped independently of its neighbours.
- R4: 64-bit lanes follow the same R1/R2 results at the extremes: carry into and out of bit 63, all-ones, zero and the signed maximum.
- R5: `satSticky` goes to 1 in the cycle after an accepted request in which at least one live lane clamped. A clamp in a lane that scalar or half vector mode discards does not set it.
- R6: `satSticky` falls only through `satClear`, one cycle after it is asserted. A clamp accepted in the same cycle as `satClear` leaves the flag at 1.
- R7: With `scalarMode`=1, only lane 0 of the selected width is computed and all other result bits are 0. `fullWidth` is ignored in this mode.
- R8: With `scalarMode`=0 and `fullWidth`=0, the low 64 bits are computed and bits [127:64] are 0. With `fullWidth`=1, all lanes are computed.
- R9: A request with `scalarMode`=0, `fullWidth`=0 and `laneSize`=3 raises `badEnc` for one cycle. It leaves `outValid` at 0 and leaves `resVec` and `satSticky` unchanged.
- R10: After reset `resVec`, `outValid`, `badEnc` and `satSticky` are 0. For an accepted request, `resVec` and `outValid`=1 appear exactly one clock after `inValid`, and `outValid` is 0 in cycles that follow no accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| opSigned | input | 1 | 0: unsigned result, 1: signed result |
| laneSize | input | 2 | Lane width code |
| scalarMode | input | 1 | Compute lane 0 only |
| fullWidth | input | 1 | Vector mode covers 128 bits instead of 64 |
| srcVec | input | 128 | Source operand |
| accVec | input | 128 | Accumulator operand |
| satClear | input | 1 | Clears the sticky flag |
| resVec | output | 128 | Registered result |
| outValid | output | 1 | Result produced this cycle |
| badEnc | output | 1 | Illegal shape was requested |
| satSticky | output | 1 | Sticky saturation flag |

## Verification
A wrong sign or zero extension inside a lane shows up in `resVec` one cycle after the request. It appears only for operands near a bound, so directed extremes are used alongside random operands. A lane mask that is off by one lane shows up in the same cycle as non-zero upper bits, or as a sticky flag raised by a discarded lane. The sticky flag is the only state that lives beyond one request. A missed set or a spurious clear surfaces on the following result, and the bench tracks the expected flag across every request, including after a `satClear`.

// File: rtl/mixsat_pkg.sv
package mixsat_pkg;
  typedef enum logic [1:0] {
    LANE_B8  = 2'd0,
    LANE_B16 = 2'd1,
    LANE_B32 = 2'd2,
    LANE_B64 = 2'd3
  } laneSz_e;

  typedef struct packed {
    logic    capture;
    logic    illegal;
    logic    opSigned;
    laneSz_e size;
  } ctrlStrobe_t;
endpackage

// File: rtl/mixsat_lane.sv
module mixsat_lane #(
  parameter int W = 8
) (
  input  logic         opSigned,
  input  logic [W-1:0] srcLane,
  input  logic [W-1:0] accLane,
  output logic [W-1:0] resLane,
  output logic         clamp
);
  generate
    if (W == 64) begin : g_wide
      logic [W-1:0] raw;
      logic toMax, toZero, sgnOvf;
      assign raw    = srcLane + accLane;
      assign toMax  = ~srcLane[W-1] & accLane[W-1] & ~raw[W-1];
      assign toZero = srcLane[W-1] & ~accLane[W-1] & raw[W-1];
      assign sgnOvf = (srcLane[W-1] & raw[W-1]) | (~accLane[W-1] & raw[W-1])
                    | (srcLane[W-1] & ~accLane[W-1]);
      always_comb begin
        resLane = raw;
        clamp   = 1'b0;
        if (!opSigned) begin
          if (toMax) begin
            resLane = '1;
            clamp   = 1'b1;
          end else if (toZero) begin
            resLane = '0;
            clamp   = 1'b1;
          end
        end else if (sgnOvf) begin
          resLane = {1'b0, {(W-1){1'b1}}};
          clamp   = 1'b1;
        end
      end
    end else begin : g_narrow
      localparam int EW = W + 2;
      logic [EW-1:0] srcExt, accExt, sum;
      logic uHigh, uNeg, sHigh, sLow;
      always_comb begin
        if (!opSigned) begin
          srcExt = {{2{srcLane[W-1]}}, srcLane};
          accExt = {2'b00, accLane};
        end else begin
          srcExt = {2'b00, srcLane};
          accExt = {{2{accLane[W-1]}}, accLane};
        end
      end
      assign sum   = srcExt + accExt;
      assign uNeg  = sum[EW-1];
      assign uHigh = ~sum[EW-1] & (sum[EW-2:W] != '0);
      assign sHigh = ~sum[EW-1] & (sum[EW-2:W-1] != '0);
      assign sLow  = sum[EW-1] & (sum[EW-2:W-1] != '1);
      always_comb begin
        resLane = sum[W-1:0];
        clamp   = 1'b0;
        if (!opSigned) begin
          if (uHigh) begin
            resLane = '1;
            clamp   = 1'b1;
          end else if (uNeg) begin
            resLane = '0;
            clamp   = 1'b1;
          end
        end else begin
          if (sHigh) begin
            resLane = {1'b0, {(W-1){1'b1}}};
            clamp   = 1'b1;
          end else if (sLow) begin
            resLane = {1'b1, {(W-1){1'b0}}};
            clamp   = 1'b1;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/mixsat_acc_ctrl.sv
module mixsat_acc_ctrl
  import mixsat_pkg::*;
#(
  parameter int REG_W = 128
) (
  input  logic              inValid,
  input  logic              opSigned,
  input  logic [1:0]        laneSize,
  input  logic              scalarMode,
  input  logic              fullWidth,
  output ctrlStrobe_t       strb,
  output logic [REG_W/8-1:0] byteKeep
);
  localparam int BYTES    = REG_W / 8;
  localparam int HALF_BYT = BYTES / 2;

  logic badShape;
  logic [4:0] scalarBytes;

  assign badShape    = ~scalarMode & ~fullWidth & (laneSize == 2'd3);
  assign scalarBytes = 5'd1 << laneSize;

  assign strb.capture  = inValid & ~badShape;
  assign strb.illegal  = inValid & badShape;
  assign strb.opSigned = opSigned;
  assign strb.size     = laneSz_e'(laneSize);

  generate
    for (genvar b = 0; b < BYTES; b++) begin : g_keep
      always_comb begin
        if (scalarMode)     byteKeep[b] = (b < int'(scalarBytes));
        else if (fullWidth) byteKeep[b] = 1'b1;
        else                byteKeep[b] = (b < HALF_BYT);
      end
    end
  endgenerate
endmodule

// File: rtl/mixsat_acc_dp.sv
module mixsat_acc_dp
  import mixsat_pkg::*;
#(
  parameter int REG_W = 128
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic [REG_W/8-1:0] byteKeep,
  input  logic [REG_W-1:0]   srcVec,
  input  logic [REG_W-1:0]   accVec,
  input  logic               satClear,
  output logic [REG_W-1:0]   resVec,
  output logic               outValid,
  output logic               badEnc,
  output logic               satSticky
);
  localparam int BYTES = REG_W / 8;
  localparam int NSIZE = 4;

  logic [NSIZE-1:0][REG_W-1:0] resBySize;
  logic [NSIZE-1:0][BYTES-1:0] satBySize;
  logic [REG_W-1:0] keepBits, keepBitsQ, merged;
  logic [BYTES-1:0] byteKeepQ;
  logic anySat;

  generate
    for (genvar g = 0; g < NSIZE; g++) begin : g_size
      localparam int W  = 8 << g;
      localparam int NL = REG_W / W;
      for (genvar l = 0; l < NL; l++) begin : g_lane
        logic clampL;
        mixsat_lane #(.W(W)) u_lane (
          .opSigned (strb.opSigned),
          .srcLane  (srcVec[l*W +: W]),
          .accLane  (accVec[l*W +: W]),
          .resLane  (resBySize[g][l*W +: W]),
          .clamp    (clampL)
        );
        assign satBySize[g][l] = clampL & byteKeep[l*(W/8)];
      end
      if (NL < BYTES) begin : g_pad
        assign satBySize[g][BYTES-1:NL] = '0;
      end
    end
    for (genvar b = 0; b < BYTES; b++) begin : g_bits
      assign keepBits[b*8 +: 8]  = {8{byteKeep[b]}};
      assign keepBitsQ[b*8 +: 8] = {8{byteKeepQ[b]}};
    end
  endgenerate

  assign merged = resBySize[strb.size] & keepBits;
  assign anySat = |satBySize[strb.size];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resVec    <= '0;
      outValid  <= 1'b0;
      badEnc    <= 1'b0;
      satSticky <= 1'b0;
      byteKeepQ <= '0;
    end else begin
      outValid <= strb.capture;
      badEnc   <= strb.illegal;
      if (strb.capture) begin
        resVec    <= merged;
        byteKeepQ <= byteKeep;
      end
      if (strb.capture && anySat) satSticky <= 1'b1;
      else if (satClear)          satSticky <= 1'b0;
    end
  end

  // R6
  sticky_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(satSticky) |-> $past(satClear));

  // R5
  sticky_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(satSticky) |-> $past(strb.capture));

  // R7
  dead_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((resVec & ~keepBitsQ) == '0));

  // R9
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    badEnc |-> ($stable(resVec) && !outValid));

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.capture, strb.illegal}));
endmodule

// File: rtl/mixsat_acc.sv
module mixsat_acc
  import mixsat_pkg::*;
#(
  parameter int REG_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             opSigned,
  input  logic [1:0]       laneSize,
  input  logic             scalarMode,
  input  logic             fullWidth,
  input  logic [REG_W-1:0] srcVec,
  input  logic [REG_W-1:0] accVec,
  input  logic             satClear,
  output logic [REG_W-1:0] resVec,
  output logic             outValid,
  output logic             badEnc,
  output logic             satSticky
);
  ctrlStrobe_t strb;
  logic [REG_W/8-1:0] byteKeep;

  mixsat_acc_ctrl #(.REG_W(REG_W)) u_ctrl (
    .inValid    (inValid),
    .opSigned   (opSigned),
    .laneSize   (laneSize),
    .scalarMode (scalarMode),
    .fullWidth  (fullWidth),
    .strb       (strb),
    .byteKeep   (byteKeep)
  );

  mixsat_acc_dp #(.REG_W(REG_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .byteKeep  (byteKeep),
    .srcVec    (srcVec),
    .accVec    (accVec),
    .satClear  (satClear),
    .resVec    (resVec),
    .outValid  (outValid),
    .badEnc    (badEnc),
    .satSticky (satSticky)
  );

  // R10
  out_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));
endmodule

// File: tb/mixsat_acc_tb.sv
module mixsat_acc_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, opSigned = 1'b0, scalarMode = 1'b0, fullWidth = 1'b0;
  logic satClear = 1'b0;
  logic [1:0] laneSize = 2'd0;
  logic [127:0] srcVec = '0, accVec = '0;
  logic [127:0] resVec;
  logic outValid, badEnc, satSticky;

  int checks = 0;
  int failures = 0;
  logic expSticky = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mixsat_acc u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSigned(opSigned),
    .laneSize(laneSize), .scalarMode(scalarMode), .fullWidth(fullWidth),
    .srcVec(srcVec), .accVec(accVec), .satClear(satClear),
    .resVec(resVec), .outValid(outValid), .badEnc(badEnc), .satSticky(satSticky)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic op, input logic [1:0] sz, input logic sc,
                                input logic q, input logic [127:0] s, input logic [127:0] a,
                                output logic [127:0] r, output logic sat);
    int w;
    int n;
    w = 8 << sz;
    n = 128 / w;
    r = '0;
    sat = 1'b0;
    for (int l = 0; l < n; l++) begin
      logic [66:0] m;
      logic signed [66:0] sv, av, sum, hiL, loL;
      logic [127:0] sh1, sh2, piece;
      bit live;
      live = sc ? (l == 0) : (q || (l * w < 64));
      if (!live) continue;
      m = (67'd1 << w) - 67'd1;
      sh1 = s >> (l * w);
      sh2 = a >> (l * w);
      sv = signed'({3'b0, sh1[63:0]} & m);
      av = signed'({3'b0, sh2[63:0]} & m);
      if (!op) begin
        if (sv[w-1]) sv = sv - signed'(67'd1 << w);
      end else begin
        if (av[w-1]) av = av - signed'(67'd1 << w);
      end
      sum = sv + av;
      if (!op) begin
        if (sum > signed'(m)) begin sum = signed'(m); sat = 1'b1; end
        else if (sum < 0) begin sum = '0; sat = 1'b1; end
      end else begin
        hiL = signed'(m >> 1);
        loL = -hiL - 67'sd1;
        if (sum > hiL) begin sum = hiL; sat = 1'b1; end
        else if (sum < loL) begin sum = loL; sat = 1'b1; end
      end
      piece = 128'(sum[63:0] & m[63:0]);
      r = r | (piece << (l * w));
    end
  endfunction

  // Issues one request, checks result and sticky flag one clock later
  task automatic doOp(input logic op, input logic [1:0] sz, input logic sc, input logic q,
                      input logic [127:0] s, input logic [127:0] a, input string tag);
    logic [127:0] er;
    logic es;
    model(op, sz, sc, q, s, a, er, es);
    @(negedge clk);
    inValid = 1'b1; opSigned = op; laneSize = sz; scalarMode = sc; fullWidth = q;
    srcVec = s; accVec = a;
    @(negedge clk);
    inValid = 1'b0;
    expSticky = expSticky | es;
    chk(outValid === 1'b1, {tag, " R10 outValid"}, 128'(outValid), 128'd1);
    chk(resVec === er, tag, resVec, er);
    chk(satSticky === expSticky, {tag, " R5 sticky"}, 128'(satSticky), 128'(expSticky));
  endtask

  task automatic clearSticky();
    @(negedge clk);
    satClear = 1'b1;
    @(negedge clk);
    satClear = 1'b0;
    expSticky = 1'b0;
    chk(satSticky === 1'b0, "R6 clear", 128'(satSticky), 128'd0);
  endtask

  task automatic t_reset();
    chk(resVec === '0, "R10 reset resVec", resVec, '0);
    chk({outValid, badEnc, satSticky} === 3'b000, "R10 reset flags",
        128'({outValid, badEnc, satSticky}), '0);
  endtask

  task automatic t_unsigned8();
    // lane0 100+100 ok, lane1 -1+0 -> 0, lane2 127+255 -> ff, lane3 -128+200 = 72
    doOp(1'b0, 2'd0, 1'b0, 1'b1, 128'h80_7f_ff_64, 128'hc8_ff_00_64, "R1 u8 directed");
    clearSticky();
    doOp(1'b0, 2'd0, 1'b0, 1'b1, 128'h01_02, 128'h10_20, "R1 u8 no clamp");
    chk(satSticky === 1'b0, "R5 no clamp keeps sticky low", 128'(satSticky), '0);
  endtask

  task automatic t_signed8();
    // lane0 200+100 -> 7f, lane1 0+(-128) = 80, lane2 255+(-128)=127
    doOp(1'b1, 2'd0, 1'b0, 1'b1, 128'hff_00_c8, 128'h80_80_64, "R2 s8 directed");
    clearSticky();
  endtask

  task automatic t_random();
    for (int i = 0; i < 160; i++) begin
      logic [127:0] s, a;
      logic [1:0] sz;
      logic op;
      s = {$urandom, $urandom, $urandom, $urandom};
      a = {$urandom, $urandom, $urandom, $urandom};
      sz = 2'(i % 4);
      op = 1'((i / 4) % 2);
      doOp(op, sz, 1'b0, 1'b1, s, a, op ? "R3 R2 random full" : "R3 R1 random full");
      if (i % 16 == 15) clearSticky();
    end
  endtask

  task automatic t_wide();
    logic [127:0] ones64 = {64'h0, 64'hffff_ffff_ffff_ffff};
    doOp(1'b0, 2'd3, 1'b0, 1'b1, {64'hffff_ffff_ffff_ffff, 64'h1},
         {64'h0, 64'hffff_ffff_ffff_ffff}, "R4 u64 high and zero");
    doOp(1'b0, 2'd3, 1'b0, 1'b1, {64'h8000_0000_0000_0000, 64'h7fff_ffff_ffff_ffff},
         {64'hffff_ffff_ffff_ffff, 64'h8000_0000_0000_0000}, "R4 u64 near bound");
    doOp(1'b1, 2'd3, 1'b0, 1'b1, {64'h8000_0000_0000_0000, 64'hffff_ffff_ffff_ffff},
         {64'hffff_ffff_ffff_ffff, 64'h1}, "R4 s64 max and pass");
    doOp(1'b1, 2'd3, 1'b1, 1'b0, ones64, {64'h0, 64'h8000_0000_0000_0000}, "R4 s64 scalar");
    clearSticky();
  endtask

  task automatic t_shapes();
    for (int sz = 0; sz < 4; sz++) begin
      doOp(1'b0, 2'(sz), 1'b1, 1'b1, {4{32'h1234_5678}}, {4{32'h0101_0101}}, "R7 scalar upper zero");
      doOp(1'b1, 2'(sz), 1'b1, 1'b0, {4{32'h9abc_def0}}, {4{32'h0202_0202}}, "R7 scalar q ignored");
    end
    for (int sz = 0; sz < 3; sz++)
      doOp(1'b1, 2'(sz), 1'b0, 1'b0, {4{32'hffff_fff0}}, {4{32'h7fff_ff7f}}, "R8 half vector");
    clearSticky();
    // lane1 would clamp but only lane0 is live in scalar mode
    doOp(1'b0, 2'd0, 1'b1, 1'b1, 128'hff_01, 128'h00_02, "R5 dead lane clamp");
    chk(satSticky === 1'b0, "R5 dead lane no sticky", 128'(satSticky), '0);
    // lanes in upper half would clamp in half-vector mode
    doOp(1'b0, 2'd1, 1'b0, 1'b0, {64'hffff_ffff_ffff_ffff, 64'h1}, {64'h0, 64'h1}, "R8 R5 upper dead");
    chk(satSticky === 1'b0, "R8 upper dead no sticky", 128'(satSticky), '0);
  endtask

  task automatic t_illegal();
    logic [127:0] held;
    held = resVec;
    @(negedge clk);
    inValid = 1'b1; opSigned = 1'b0; laneSize = 2'd3; scalarMode = 1'b0; fullWidth = 1'b0;
    srcVec = '1; accVec = {2{64'hffff_ffff_ffff_fff0}};
    @(negedge clk);
    inValid = 1'b0;
    chk(badEnc === 1'b1, "R9 badEnc", 128'(badEnc), 128'd1);
    chk(outValid === 1'b0, "R9 no outValid", 128'(outValid), '0);
    chk(resVec === held, "R9 result held", resVec, held);
    chk(satSticky === expSticky, "R9 sticky held", 128'(satSticky), 128'(expSticky));
    @(negedge clk);
    chk(badEnc === 1'b0, "R9 badEnc one cycle", 128'(badEnc), '0);
    chk(outValid === 1'b0, "R10 idle outValid", 128'(outValid), '0);
  endtask

  task automatic t_clearRace();
    @(negedge clk);
    inValid = 1'b1; opSigned = 1'b1; laneSize = 2'd0; scalarMode = 1'b1; fullWidth = 1'b0;
    srcVec = 128'hff; accVec = 128'h7f; satClear = 1'b1;
    @(negedge clk);
    inValid = 1'b0; satClear = 1'b0;
    expSticky = 1'b1;
    chk(satSticky === 1'b1, "R6 clamp beats clear", 128'(satSticky), 128'd1);
    chk(resVec === 128'h7f, "R2 scalar s8 max", resVec, 128'h7f);
    repeat (3) @(negedge clk);
    chk(satSticky === 1'b1, "R6 sticky persists", 128'(satSticky), 128'd1);
    clearSticky();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_unsigned8();
    t_signed8();
    t_wide();
    t_shapes();
    t_illegal();
    t_clearRace();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule